// File: doc/BRIEF.md
# Transmit Impedance Segment Allocator

This block converts the measured pull-up (P) and pull-down (N) impedance codes of a transmit driver into enable patterns for the driver's segment groups. The driver is built from main, pre-cursor, post-cursor and margin segments, and the allocation is counted in half-segment units. A start pulse either skips the work, when that PHY half has already been calibrated, or runs a full pass. A full pass clears the software-override enable, raises a request to the analog calibration engine, waits for done or error, range-checks the two codes and then trims enabled strength one step per clock until the total matches the measurement.

Trimming takes main segments away in pairs until at most one half unit of main remains. After that it takes margin segments away, pull-down first when the two margin groups are level and pull-up otherwise. Main, pre-cursor and post-cursor enables are emitted as a thermometer code with an extra half-weight bit at the MSB. Margin enables are emitted as a plain thermometer code. The block signals the end of each start request with a one-cycle done pulse, and a fail flag is valid alongside it.

Top module: `tx_zcal_alloc`

## Requirements
- R1: A start on a half that has no completion mark drives `sw_ovr_o` low and raises `cal_req_o`. The request stays high until `cal_done_i` or a failing `cal_err_i` is seen.
- R2: If `cal_err_i` is seen while waiting and `nom_en_i` is low, the pass ends with `done_o` and `fail_o` both set. The half stays unmarked, so a later start calibrates it again.
- R3: While `nom_en_i` is high, `cal_err_i` is ignored and the block waits for `cal_done_i`.
- R4: Each working code is bits [8:2] of its 9-bit input (the input divided by 4). When `nom_en_i` is high, `nom_val_i` replaces both codes.
- R5: If either working code lies outside 32..66 inclusive, the pass ends with `fail_o` set and all segment enables keep their previous values.
- R6: The working value is code minus 67. If it is odd, the main count starts at 12 instead of 13 and the value is raised by one.
- R7: On each clock while the value is negative: if the main count is above 1 it drops by 2; otherwise, if either margin count is nonzero, pull-down drops by 2 when the two margin counts are equal, and pull-up drops by 2 when they differ. The value rises by 2 on every such clock. Margin counts start at 16.
- R8: Main enables (7 bits) carry the count's LSB in bit 6 and a thermometer code of count>>1 in bits 5:0.
- R9: Margin enables (8 bits) are a thermometer code of (count+1)/2.
- R10: Pre-cursor enable is 5'b11111 and post-cursor enable is 7'h7F, which is the half-unit encoding of 9 and 13. The pre-cursor, post-cursor and margin selects are all zero.
- R11: A successful pass marks its half (`half_i`). A later start on a marked half gives a done pulse with `fail_o` low, raises no request, and leaves all enables unchanged. The other half is not affected.
- R12: `done_o` is a single-cycle pulse for each accepted start. `fail_o` is updated with it and holds until the next one.
- R13: After reset, `cal_req_o`, `done_o` and `fail_o` are low and `sw_ovr_o` is high. The main enables read 7'h7F and the margin enables read 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| half_i | input | 1 | PHY half selected by the start |
| nom_en_i | input | 1 | Use nominal value instead of measured codes |
| nom_val_i | input | 7 | Nominal code in half units |
| cal_done_i | input | 1 | Calibration engine finished |
| cal_err_i | input | 1 | Calibration engine error |
| zcal_p_i | input | 9 | Measured pull-up code |
| zcal_n_i | input | 9 | Measured pull-down code |
| cal_req_o | output | 1 | Request to the calibration engine |
| sw_ovr_o | output | 1 | Software-override enable |
| done_o | output | 1 | End-of-request pulse |
| fail_o | output | 1 | Failure flag, valid with done |
| pre_en_o | output | 5 | Pre-cursor enables |
| pre_sel_o | output | 5 | Pre-cursor select |
| post_en_o | output | 7 | Post-cursor enables |
| post_sel_o | output | 7 | Post-cursor select |
| p_main_o | output | 7 | P main enables |
| p_mpu_o | output | 8 | P margin pull-up enables |
| p_mpd_o | output | 8 | P margin pull-down enables |
| n_main_o | output | 7 | N main enables |
| n_mpu_o | output | 8 | N margin pull-up enables |
| n_mpd_o | output | 8 | N margin pull-down enables |
| margin_sel_o | output | 8 | Margin select |

## Verification
The bench drives codes at both ends of the legal range (32 and 66) and one step outside each end (31 and 67). A design that got the range check wrong would either fail a legal code or overwrite the enables with a bad one. A code of 32 forces the longest trim, which runs past the main segments into alternating margin removal. An off-by-one in the alternation would show up as the pull-up and pull-down counts swapped. Odd and even working values check the main count drop of one, and codes with nonzero low bits check the divide by 4. The bench also checks that an error is masked when a nominal value is set, that a marked half skips calibration without touching the enables, and that an unmarked half retries after a failure. A design that kept the completion mark in one shared flag would skip the second half.

// File: rtl/tzc_pkg.sv
`timescale 1ns/1ps
package tzc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CHECK = 2'd2,
    ST_TRIM  = 2'd3
  } tzc_state_e;
endpackage

// File: rtl/tzc_seg_encode.sv
`timescale 1ns/1ps
// Count-to-enable encoder. HALF=1: MSB carries the count LSB and the low bits
// are a thermometer of count>>1. HALF=0: thermometer of (count+1)/2.
module tzc_seg_encode #(
  parameter int N_IN = 4,
  parameter int W    = 7,
  parameter bit HALF = 1'b1
) (
  input  logic [N_IN-1:0] x_i,
  output logic [W-1:0]    y_o
);
  logic [N_IN:0] lvl;

  if (HALF) begin : g_half
    assign lvl = {1'b0, x_i} >> 1;
    assign y_o[W-1] = x_i[0];
    for (genvar i = 0; i < W-1; i++) begin : g_bit
      assign y_o[i] = (int'(lvl) > i);
    end
  end else begin : g_plain
    assign lvl = ({1'b0, x_i} + (N_IN+1)'(1)) >> 1;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = (int'(lvl) > i);
    end
  end
endmodule

// File: rtl/tzc_trim_leg.sv
`timescale 1ns/1ps
// One driver leg: loads a code, then removes half-unit strength one step per
// clock while the working value stays negative.
module tzc_trim_leg #(
  parameter int CODE_W   = 7,
  parameter int MAIN_MAX = 13,
  parameter int MARG_MAX = 16,
  parameter int TOTAL    = 67,
  parameter int MN_W     = 4,
  parameter int MG_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [MN_W-1:0]   main_o,
  output logic [MG_W-1:0]   mpu_o,
  output logic [MG_W-1:0]   mpd_o,
  output logic              busy_o
);
  localparam int VAL_W = CODE_W + 2;

  logic [VAL_W-1:0] val_q, val_d, diff;
  logic [MN_W-1:0]  main_q, main_d;
  logic [MG_W-1:0]  mpu_q, mpu_d, mpd_q, mpd_d;

  assign diff = {2'b00, code_i} - VAL_W'(TOTAL);

  always_comb begin
    val_d  = val_q;
    main_d = main_q;
    mpu_d  = mpu_q;
    mpd_d  = mpd_q;
    if (load_i) begin
      mpu_d = MG_W'(MARG_MAX);
      mpd_d = MG_W'(MARG_MAX);
      if (diff[0]) begin
        main_d = MN_W'(MAIN_MAX - 1);
        val_d  = diff + VAL_W'(1);
      end else begin
        main_d = MN_W'(MAIN_MAX);
        val_d  = diff;
      end
    end else if (val_q[VAL_W-1]) begin
      if (main_q > MN_W'(1)) begin
        main_d = main_q - MN_W'(2);
      end else if ((mpu_q != '0) || (mpd_q != '0)) begin
        if (mpu_q == mpd_q) mpd_d = mpd_q - MG_W'(2);
        else                mpu_d = mpu_q - MG_W'(2);
      end
      val_d = val_q + VAL_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      main_q <= MN_W'(MAIN_MAX);
      mpu_q  <= MG_W'(MARG_MAX);
      mpd_q  <= MG_W'(MARG_MAX);
    end else begin
      val_q  <= val_d;
      main_q <= main_d;
      mpu_q  <= mpu_d;
      mpd_q  <= mpd_d;
    end
  end

  assign main_o = main_q;
  assign mpu_o  = mpu_q;
  assign mpd_o  = mpd_q;
  assign busy_o = val_q[VAL_W-1];
endmodule

// File: rtl/tx_zcal_alloc.sv
`timescale 1ns/1ps
module tx_zcal_alloc #(
  parameter int CODE_W_IN = 9,
  parameter int PRE_W     = 5,
  parameter int POST_W    = 7,
  parameter int MAIN_W    = 7,
  parameter int MARG_W    = 8,
  parameter int PRE_MAX   = 9,
  parameter int POST_MAX  = 13,
  parameter int MAIN_MAX  = 13,
  parameter int MARG_MAX  = 16,
  parameter int ZC_MIN    = 32,
  parameter int ZC_MAX    = 66
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   half_i,
  input  logic                   nom_en_i,
  input  logic [CODE_W_IN-3:0]   nom_val_i,
  input  logic                   cal_done_i,
  input  logic                   cal_err_i,
  input  logic [CODE_W_IN-1:0]   zcal_p_i,
  input  logic [CODE_W_IN-1:0]   zcal_n_i,
  output logic                   cal_req_o,
  output logic                   sw_ovr_o,
  output logic                   done_o,
  output logic                   fail_o,
  output logic [PRE_W-1:0]       pre_en_o,
  output logic [PRE_W-1:0]       pre_sel_o,
  output logic [POST_W-1:0]      post_en_o,
  output logic [POST_W-1:0]      post_sel_o,
  output logic [MAIN_W-1:0]      p_main_o,
  output logic [MARG_W-1:0]      p_mpu_o,
  output logic [MARG_W-1:0]      p_mpd_o,
  output logic [MAIN_W-1:0]      n_main_o,
  output logic [MARG_W-1:0]      n_mpu_o,
  output logic [MARG_W-1:0]      n_mpd_o,
  output logic [MARG_W-1:0]      margin_sel_o
);
  import tzc_pkg::*;

  localparam int CODE_W = CODE_W_IN - 2;
  localparam int TOTAL  = PRE_MAX + POST_MAX + 2*MARG_MAX + MAIN_MAX;
  localparam int MN_W   = $clog2(MAIN_MAX + 1);
  localparam int MG_W   = $clog2(MARG_MAX + 1);
  localparam int PR_W   = $clog2(PRE_MAX + 1);
  localparam int PO_W   = $clog2(POST_MAX + 1);

  tzc_state_e state_q, state_d;
  logic       half_q, half_d;
  logic       req_q, req_d, ovr_q, ovr_d, done_q, done_d, fail_q, fail_d;
  logic [1:0] cplt_q, cplt_d;
  logic       load;

  logic [CODE_W-1:0] leg_code [2];
  logic [1:0]        code_ok, leg_busy;
  logic [MN_W-1:0]   leg_main [2];
  logic [MG_W-1:0]   leg_mpu  [2];
  logic [MG_W-1:0]   leg_mpd  [2];
  logic [MAIN_W-1:0] main_enc [2];
  logic [MARG_W-1:0] mpu_enc  [2];
  logic [MARG_W-1:0] mpd_enc  [2];

  assign leg_code[0] = nom_en_i ? nom_val_i : zcal_p_i[CODE_W_IN-1:2];
  assign leg_code[1] = nom_en_i ? nom_val_i : zcal_n_i[CODE_W_IN-1:2];

  for (genvar g = 0; g < 2; g++) begin : g_leg
    assign code_ok[g] = (leg_code[g] >= CODE_W'(ZC_MIN)) &&
                        (leg_code[g] <= CODE_W'(ZC_MAX));

    tzc_trim_leg #(
      .CODE_W(CODE_W), .MAIN_MAX(MAIN_MAX), .MARG_MAX(MARG_MAX),
      .TOTAL(TOTAL), .MN_W(MN_W), .MG_W(MG_W)
    ) u_leg (
      .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(leg_code[g]),
      .main_o(leg_main[g]), .mpu_o(leg_mpu[g]), .mpd_o(leg_mpd[g]),
      .busy_o(leg_busy[g])
    );

    tzc_seg_encode #(.N_IN(MN_W), .W(MAIN_W), .HALF(1'b1)) u_main (
      .x_i(leg_main[g]), .y_o(main_enc[g]));
    tzc_seg_encode #(.N_IN(MG_W), .W(MARG_W), .HALF(1'b0)) u_mpu (
      .x_i(leg_mpu[g]), .y_o(mpu_enc[g]));
    tzc_seg_encode #(.N_IN(MG_W), .W(MARG_W), .HALF(1'b0)) u_mpd (
      .x_i(leg_mpd[g]), .y_o(mpd_enc[g]));
  end

  tzc_seg_encode #(.N_IN(PR_W), .W(PRE_W), .HALF(1'b1)) u_pre (
    .x_i(PR_W'(PRE_MAX)), .y_o(pre_en_o));
  tzc_seg_encode #(.N_IN(PO_W), .W(POST_W), .HALF(1'b1)) u_post (
    .x_i(PO_W'(POST_MAX)), .y_o(post_en_o));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    req_d   = req_q;
    ovr_d   = ovr_q;
    done_d  = 1'b0;
    fail_d  = fail_q;
    cplt_d  = cplt_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          half_d = half_i;
          if (cplt_q[half_i]) begin
            done_d = 1'b1;
            fail_d = 1'b0;
          end else begin
            ovr_d   = 1'b0;
            req_d   = 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cal_err_i && !nom_en_i) begin
          req_d   = 1'b0;
          done_d  = 1'b1;
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (cal_done_i) begin
          req_d   = 1'b0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (&code_ok) begin
          load    = 1'b1;
          state_d = ST_TRIM;
        end else begin
          done_d  = 1'b1;
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_TRIM: begin
        if (leg_busy == 2'b00) begin
          done_d         = 1'b1;
          fail_d         = 1'b0;
          cplt_d[half_q] = 1'b1;
          state_d        = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      req_q   <= 1'b0;
      ovr_q   <= 1'b1;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      cplt_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      req_q   <= req_d;
      ovr_q   <= ovr_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      cplt_q  <= cplt_d;
    end
  end

  assign cal_req_o    = req_q;
  assign sw_ovr_o     = ovr_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign pre_sel_o    = '0;
  assign post_sel_o   = '0;
  assign margin_sel_o = '0;
  assign p_main_o     = main_enc[0];
  assign p_mpu_o      = mpu_enc[0];
  assign p_mpd_o      = mpd_enc[0];
  assign n_main_o     = main_enc[1];
  assign n_mpu_o      = mpu_enc[1];
  assign n_mpd_o      = mpd_enc[1];
endmodule

// File: rtl/tzc_alloc_chk.sv
`timescale 1ns/1ps
module tzc_alloc_chk #(
  parameter int MAIN_W = 7,
  parameter int MARG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cal_req_o,
  input logic              sw_ovr_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [MAIN_W-1:0] p_main_o,
  input logic [MARG_W-1:0] p_mpu_o,
  input logic [MARG_W-1:0] p_mpd_o,
  input logic [MAIN_W-1:0] n_main_o,
  input logic [MARG_W-1:0] n_mpu_o,
  input logic [MARG_W-1:0] n_mpd_o
);
  assert_req_ovr_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |-> !sw_ovr_o);

  assert_req_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req_o) |-> $past(start_i));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fail_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> done_o);

  assert_pd_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(p_mpd_o) <= $countones(p_mpu_o)) &&
    ($countones(n_mpd_o) <= $countones(n_mpu_o)));

  assert_main_before_margin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_mpu_o != '1) || (p_mpd_o != '1)) |-> (p_main_o[MAIN_W-2:0] == '0));

  assert_main_before_margin_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_mpu_o != '1) || (n_mpd_o != '1)) |-> (n_main_o[MAIN_W-2:0] == '0));
endmodule

bind tx_zcal_alloc tzc_alloc_chk #(.MAIN_W(MAIN_W), .MARG_W(MARG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_req_o(cal_req_o),
  .sw_ovr_o(sw_ovr_o), .done_o(done_o), .fail_o(fail_o),
  .p_main_o(p_main_o), .p_mpu_o(p_mpu_o), .p_mpd_o(p_mpd_o),
  .n_main_o(n_main_o), .n_mpu_o(n_mpu_o), .n_mpd_o(n_mpd_o)
);

// File: tb/tx_zcal_alloc_bench.sv
`timescale 1ns/1ps
module tx_zcal_alloc_bench;
  logic clk = 1'b0;
  logic rst_n, start_i, half_i, nom_en_i, cal_done_i, cal_err_i;
  logic [6:0] nom_val_i;
  logic [8:0] zcal_p_i, zcal_n_i;
  logic cal_req_o, sw_ovr_o, done_o, fail_o;
  logic [4:0] pre_en_o, pre_sel_o;
  logic [6:0] post_en_o, post_sel_o, p_main_o, n_main_o;
  logic [7:0] p_mpu_o, p_mpd_o, n_mpu_o, n_mpd_o, margin_sel_o;

  always #2.5 clk = ~clk;

  tx_zcal_alloc u_tx_zcal_alloc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half_i),
    .nom_en_i(nom_en_i), .nom_val_i(nom_val_i), .cal_done_i(cal_done_i),
    .cal_err_i(cal_err_i), .zcal_p_i(zcal_p_i), .zcal_n_i(zcal_n_i),
    .cal_req_o(cal_req_o), .sw_ovr_o(sw_ovr_o), .done_o(done_o), .fail_o(fail_o),
    .pre_en_o(pre_en_o), .pre_sel_o(pre_sel_o), .post_en_o(post_en_o),
    .post_sel_o(post_sel_o), .p_main_o(p_main_o), .p_mpu_o(p_mpu_o),
    .p_mpd_o(p_mpd_o), .n_main_o(n_main_o), .n_mpu_o(n_mpu_o),
    .n_mpd_o(n_mpd_o), .margin_sel_o(margin_sel_o)
  );

  typedef struct {
    bit    fail;
    int    pm, pu, pd, nm, nu, nd;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0, n_done = 0, n_req = 0, cyc = 0;
  bit   m_flag [2];
  int   cur [6];
  bit   resp_err = 0;
  int   resp_lat = 3, lat_cnt = 0;
  bit   prev_req = 0, prev_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int enc_half(input int x, input int w);
    return ((x & 1) << (w - 1)) | ((1 << (x >> 1)) - 1);
  endfunction

  function automatic int enc_marg(input int x);
    return (1 << ((x + 1) / 2)) - 1;
  endfunction

  // Reference trim from R6/R7
  task automatic model(input int code, output int m, output int u, output int d);
    int v;
    v = code - 67; m = 13; u = 16; d = 16;
    if ((v & 1) != 0) begin m = m - 1; v = v + 1; end
    while (v < 0) begin
      if (m > 1) m = m - 2;
      else if (u + d > 0) begin
        if (u == d) d = d - 2; else u = u - 2;
      end
      v = v + 2;
    end
  endtask

  // Calibration engine responder
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cal_done_i = 0; cal_err_i = 0; lat_cnt = 0; prev_req = 0;
    end else begin
      if (cal_req_o && !prev_req) begin
        n_req++;
        chk(sw_ovr_o == 1'b0, "R1 override low at request", sw_ovr_o, 0);
      end
      prev_req = cal_req_o;
      if (cal_req_o) begin
        lat_cnt++;
        if (lat_cnt >= resp_lat) begin
          cal_done_i = 1; cal_err_i = resp_err;
        end
      end else begin
        lat_cnt = 0; cal_done_i = 0; cal_err_i = 0;
      end
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done_o == 1'b0, "R12 done single cycle", done_o, 0);
      prev_done = done_o;
      if (done_o) begin
        n_done++;
        if (q.size() == 0) chk(0, "R12 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(fail_o == e.fail, {e.tag, " fail"}, fail_o, e.fail);
          chk(p_main_o == enc_half(e.pm, 7), {e.tag, " R8 p_main"}, p_main_o, enc_half(e.pm, 7));
          chk(n_main_o == enc_half(e.nm, 7), {e.tag, " R8 n_main"}, n_main_o, enc_half(e.nm, 7));
          chk(p_mpu_o == enc_marg(e.pu), {e.tag, " R9 p_mpu"}, p_mpu_o, enc_marg(e.pu));
          chk(p_mpd_o == enc_marg(e.pd), {e.tag, " R9 p_mpd"}, p_mpd_o, enc_marg(e.pd));
          chk(n_mpu_o == enc_marg(e.nu), {e.tag, " R9 n_mpu"}, n_mpu_o, enc_marg(e.nu));
          chk(n_mpd_o == enc_marg(e.nd), {e.tag, " R9 n_mpd"}, n_mpd_o, enc_marg(e.nd));
          chk(pre_en_o == 5'h1F && post_en_o == 7'h7F, "R10 pre/post enables",
              {pre_en_o, post_en_o}, {5'h1F, 7'h7F});
          chk(pre_sel_o == 0 && post_sel_o == 0 && margin_sel_o == 0, "R10 selects zero",
              {pre_sel_o, post_sel_o, margin_sel_o}, 0);
        end
      end
    end else prev_done = 0;
  end

  task automatic do_reset();
    rst_n = 0; start_i = 0; half_i = 0; nom_en_i = 0; nom_val_i = 0;
    zcal_p_i = 0; zcal_n_i = 0; resp_err = 0;
    m_flag[0] = 0; m_flag[1] = 0;
    cur[0] = 13; cur[1] = 16; cur[2] = 16; cur[3] = 13; cur[4] = 16; cur[5] = 16;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run(input bit h, input int p9, input int n9, input bit err,
                     input bit nen, input int nval, input string tag);
    exp_t e;
    int pc, nc, d0, r0;
    bit calib;
    calib = !m_flag[h];
    e.fail = 0; e.tag = tag;
    if (calib) begin
      if (err && !nen) e.fail = 1;
      else begin
        pc = nen ? nval : (p9 >> 2);
        nc = nen ? nval : (n9 >> 2);
        if (pc < 32 || pc > 66 || nc < 32 || nc > 66) e.fail = 1;
        else begin
          model(pc, cur[0], cur[1], cur[2]);
          model(nc, cur[3], cur[4], cur[5]);
          m_flag[h] = 1;
        end
      end
    end
    e.pm = cur[0]; e.pu = cur[1]; e.pd = cur[2];
    e.nm = cur[3]; e.nu = cur[4]; e.nd = cur[5];
    q.push_back(e);
    zcal_p_i = p9[8:0]; zcal_n_i = n9[8:0]; resp_err = err;
    nom_en_i = nen; nom_val_i = nval[6:0]; half_i = h;
    d0 = n_done; r0 = n_req;
    start_i = 1; @(negedge clk); start_i = 0;
    for (int i = 0; i < 200 && n_done == d0; i++) @(negedge clk);
    chk(n_done == d0 + 1, {tag, " R12 done seen"}, n_done - d0, 1);
    chk((n_req - r0) == int'(calib), {tag, " R11 request count"}, n_req - r0, int'(calib));
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R13 reset state
    chk(cal_req_o == 0 && done_o == 0 && fail_o == 0, "R13 idle outputs",
        {cal_req_o, done_o, fail_o}, 0);
    chk(sw_ovr_o == 1, "R13 override high", sw_ovr_o, 1);
    chk(p_main_o == 7'h7F && n_main_o == 7'h7F, "R13 main full", p_main_o, 7'h7F);
    chk(p_mpu_o == 8'hFF && n_mpd_o == 8'hFF, "R13 margin full", p_mpu_o, 8'hFF);

    run(0, 66*4+3, 32*4, 0, 0, 0, "R6 R7 boundary 66/32");
    run(0, 40*4, 40*4, 0, 0, 0, "R11 skip marked half");
    run(1, 50*4, 50*4, 1, 0, 0, "R2 error fails");
    run(1, 50*4, 50*4, 1, 1, 45, "R3 R4 nominal masks error");
    run(1, 60*4, 60*4, 0, 0, 0, "R11 skip half1");

    do_reset();
    run(0, 31*4+3, 50*4, 0, 0, 0, "R5 below range");
    run(0, 50*4, 67*4, 0, 0, 0, "R5 above range");
    run(0, 32*4, 66*4+2, 0, 0, 0, "R5 R7 in range edges");
    run(1, 44*4+1, 57*4+3, 0, 0, 0, "R4 R6 low bits dropped");

    do_reset();
    run(1, 50*4, 50*4, 1, 0, 0, "R2 error first");
    run(1, 47*4, 38*4, 0, 0, 0, "R2 retry after error");
    run(0, 500, 3, 0, 1, 33, "R4 nominal replaces codes");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule